// File: doc/BRIEF.md
# Channel Rate Converter with Linear Sample Blending

This block converts one audio channel from its stored sample rate to a fixed output rate. A free-running divider makes one output tick every 96 clock cycles, which gives 281.25 kHz from a 27 MHz clock. On each tick, while the channel is active, a 19-bit phase increment is added to a 19-bit accumulator, and the result is kept modulo 2^19. When the sum carries out of the top bit, the block sends a one-cycle request to the sample fetcher.

A fetched sample comes back on a data port with a valid strobe. It is accepted only if a request is still waiting. On acceptance, the held current sample moves into the previous-sample register and the new word becomes the current sample. The 16-bit unsigned output is either the current sample, or a straight-line blend from the previous sample toward the current one when blending is enabled. The blend weight is the top eight bits of the accumulator. A mode input selects the idle level that both sample registers hold after reset: mid-scale for one 16-bit sample, or mid-scale in each byte for packed 8-bit data.

Top module: `phase_interp_chan`

## Requirements
- R1: With the channel active, the accumulator advances exactly once in every window of 96 consecutive clock cycles.
- R2: While `chan_active` is low, the accumulator holds its value and `fetch_req` stays low.
- R3: Each advance adds `phase_inc` to the accumulator modulo 2^19. An advance that carries out of bit 18 raises `fetch_req` for exactly one cycle, and an advance without a carry raises nothing.
- R4: A `fetch_valid` pulse while a request is outstanding copies the current sample to the previous sample and loads `fetch_data` as the current sample.
- R5: With `interp_en` low, `sample_out` equals the current sample, one cycle after the sample changes.
- R6: With `interp_en` high, `sample_out` equals prev + floor((cur − prev) · w / 256). Here w is accumulator bits 18:11 taken as an unsigned number, and the difference is signed. When w is 0 the output is the previous sample.
- R7: A `fetch_valid` pulse while no request is outstanding changes neither sample register.
- R8: After reset, the accumulator is 0 and both sample registers hold 0x8000 if `wide_mode` is 1, or 0x8080 if `wide_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_active | input | 1 | Channel is playing; gates accumulator advance |
| wide_mode | input | 1 | 1: 16-bit samples, 0: packed 8-bit samples (selects idle level) |
| interp_en | input | 1 | Enable linear blend between previous and current sample |
| phase_inc | input | 19 | Phase increment added per tick |
| fetch_req | output | 1 | One-cycle request for the next sample |
| fetch_valid | input | 1 | Fetched sample present on fetch_data |
| fetch_data | input | 16 | Fetched sample word |
| sample_out | output | 16 | Channel output sample, unsigned |

## Verification
The tick divider is not visible at the ports, so the bench cannot simply wait for a tick. Instead it holds `chan_active` high for an exact multiple of 96 cycles. Any such window contains exactly the same number of ticks, whatever the divider phase, so the bench's own accumulator model stays exact. The hardest state to reach is a return strobe with no request waiting. The bench gets there by disabling its fetch responder and pulsing `fetch_valid` by hand, then checks both sample registers through the output, with blending off and with the weight at zero.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int PHASE_W  = 19;
  localparam int SAMPLE_W = 16;
  localparam int WEIGHT_W = 8;
  localparam int TICK_DIV = 96;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [PHASE_W-1:0]  phase_t;

  // Idle level held by the sample registers out of reset
  function automatic sample_t idle_level(input logic wide);
    return wide ? sample_t'(16'h8000) : sample_t'(16'h8080);
  endfunction
endpackage

// File: rtl/pi_tick_gen.sv
module pi_tick_gen #(
  parameter int DIV = 96
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/pi_phase_acc.sv
module pi_phase_acc #(
  parameter int PW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic [PW-1:0] inc,
  output logic [PW-1:0] acc,
  output logic          wrap_req
);
  logic [PW-1:0] acc_q, acc_d;
  logic          req_q, req_d;
  logic          step;
  logic [PW:0]   sum;

  always_comb begin
    step  = tick & active;
    sum   = {1'b0, acc_q} + {1'b0, inc};
    acc_d = step ? sum[PW-1:0] : acc_q;
    req_d = step & sum[PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      req_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      req_q <= req_d;
    end
  end

  assign acc      = acc_q;
  assign wrap_req = req_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && active) |=> $stable(acc_q) && !req_q);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R3
  req_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (acc_q < $past(acc_q)) || ($past(inc) == '0 ? 1'b0 : acc_q <= $past(acc_q)));
endmodule

// File: rtl/pi_sample_pipe.sv
module pi_sample_pipe
  import pi_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          wrap_req,
  input  logic          data_valid,
  input  logic [SW-1:0] data_in,
  output logic [SW-1:0] cur,
  output logic [SW-1:0] prev
);
  logic [SW-1:0] cur_q, cur_d, prev_q, prev_d;
  logic          pend_q, pend_d;
  logic          accept;

  always_comb begin
    accept = data_valid & pend_q;
    pend_d = wrap_req | (pend_q & ~data_valid);
    cur_d  = accept ? data_in : cur_q;
    prev_d = accept ? cur_q   : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= SW'(idle_level(wide_mode));
      prev_q <= SW'(idle_level(wide_mode));
      pend_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && pend_q) |=> (prev_q == $past(cur_q)) && (cur_q == $past(data_in)));
  // R7
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !pend_q) |=> $stable(cur_q) && $stable(prev_q));
endmodule

// File: rtl/pi_blend.sv
module pi_blend
  import pi_pkg::*;
#(
  parameter int SW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          interp_en,
  input  logic [WW-1:0] weight,
  input  logic [SW-1:0] cur,
  input  logic [SW-1:0] prev,
  output logic [SW-1:0] out
);
  localparam int DW = SW + 1;
  localparam int MW = DW + WW + 1;

  logic signed [DW-1:0] diff;
  logic signed [MW-1:0] prod, scaled, sum;
  logic        [SW-1:0] out_q, out_d;

  always_comb begin
    diff   = $signed({1'b0, cur}) - $signed({1'b0, prev});
    prod   = MW'(diff) * $signed({{(MW-WW){1'b0}}, weight});
    scaled = prod >>> WW;
    sum    = $signed({{(MW-SW){1'b0}}, prev}) + scaled;
    out_d  = interp_en ? sum[SW-1:0] : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= SW'(idle_level(wide_mode));
    else        out_q <= out_d;
  end

  assign out = out_q;

  // R5
  direct_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interp_en |=> out_q == $past(cur));
  // R6
  flat_blend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (interp_en && (cur == prev || weight == '0)) |=> out_q == $past(prev));
  // R6
  blend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum[MW-1:SW] == '0);
endmodule

// File: rtl/phase_interp_chan.sv
module phase_interp_chan
  import pi_pkg::*;
#(
  parameter int DIV = TICK_DIV,
  parameter int PW  = PHASE_W,
  parameter int SW  = SAMPLE_W,
  parameter int WW  = WEIGHT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_active,
  input  logic          wide_mode,
  input  logic          interp_en,
  input  logic [PW-1:0] phase_inc,
  output logic          fetch_req,
  input  logic          fetch_valid,
  input  logic [SW-1:0] fetch_data,
  output logic [SW-1:0] sample_out
);
  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          tick;
  logic [PW-1:0] acc;
  logic          wrap_req;
  logic [SW-1:0] cur, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pi_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(tick));

  pi_phase_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .active(chan_active),
    .inc(phase_inc), .acc(acc), .wrap_req(wrap_req));

  pi_sample_pipe #(.SW(SW)) u_pipe (
    .clk(clk), .rst_n(rst_s_n), .wide_mode(wide_mode), .wrap_req(wrap_req),
    .data_valid(fetch_valid), .data_in(fetch_data), .cur(cur), .prev(prev));

  pi_blend #(.SW(SW), .WW(WW)) u_blend (
    .clk(clk), .rst_n(rst_s_n), .wide_mode(wide_mode), .interp_en(interp_en),
    .weight(acc[PW-1 -: WW]), .cur(cur), .prev(prev), .out(sample_out));

  assign fetch_req = wrap_req;
endmodule

// File: tb/sim_phase_interp_chan.sv
module sim_phase_interp_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_active = 1'b0;
  logic        wide_mode = 1'b1;
  logic        interp_en = 1'b0;
  logic [18:0] phase_inc = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_data = '0;
  logic        fetch_req;
  logic [15:0] sample_out;

  int n_checks = 0;
  int n_fail   = 0;
  int req_seen = 0;
  bit resp_en  = 1'b1;
  int resp_idx = 0;
  logic [15:0] resp_list [0:7];
  int model_acc = 0;

  always #5 clk = ~clk;

  phase_interp_chan u0 (
    .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .wide_mode(wide_mode),
    .interp_en(interp_en), .phase_inc(phase_inc), .fetch_req(fetch_req),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .sample_out(sample_out));

  task automatic chk(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  function automatic int blend(input int prv, input int cr, input int acc);
    int w, p;
    w = (acc >> 11) & 255;
    p = (cr - prv) * w;
    p = p >>> 8;
    return prv + p;
  endfunction

  // Fetch responder: answers each request three cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req) begin
        req_seen++;
        if (resp_en) begin
          repeat (3) @(negedge clk);
          fetch_data  = resp_list[resp_idx];
          fetch_valid = 1'b1;
          resp_idx++;
          @(negedge clk);
          fetch_valid = 1'b0;
        end
      end
    end
  end

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n = 1'b0; chan_active = 1'b0; interp_en = 1'b0; wide_mode = wide;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_acc = 0; resp_idx = 0; req_seen = 0;
  endtask

  task automatic run_ticks(input int k, input int inc);
    phase_inc = 19'(inc);
    @(negedge clk);
    chan_active = 1'b1;
    repeat (96 * k) @(negedge clk);
    chan_active = 1'b0;
    repeat (8) @(negedge clk);
    model_acc = (model_acc + k * inc) % (1 << 19);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R8 idle level 8-bit", sample_out, 16'h8080);
    do_reset(1'b1);
    chk("R8 idle level 16-bit", sample_out, 16'h8000);
    interp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 prev idle 16-bit", sample_out, 16'h8000);
  endtask

  task automatic t_hold;
    do_reset(1'b1);
    phase_inc = 19'h7FFFF;
    repeat (400) @(negedge clk);
    chk("R2 no request while inactive", req_seen, 0);
    chk("R2 output held while inactive", sample_out, 16'h8000);
  endtask

  task automatic t_rate;
    do_reset(1'b1);
    resp_list[0] = 16'h4321;
    run_ticks(3, 32'h20000);
    chk("R1 no carry after three steps", req_seen, 0);
    run_ticks(1, 32'h20000);
    chk("R1 R3 carry on fourth step", req_seen, 1);
    chk("R4 R5 new sample on output", sample_out, 16'h4321);
    interp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 zero weight gives previous", sample_out, 16'h8000);
  endtask

  task automatic t_blend;
    do_reset(1'b1);
    resp_list[0] = 16'h1000; resp_list[1] = 16'h9000; resp_list[2] = 16'h0100;
    run_ticks(4, 32'h40000);
    chk("R3 two carries", req_seen, 2);
    run_ticks(1, 32'h10000);
    interp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 rising blend w=32", sample_out, blend(32'h1000, 32'h9000, model_acc));
    chk("R6 rising blend value", sample_out, 16'h2000);
    interp_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 direct current sample", sample_out, 16'h9000);
    interp_en = 1'b1;
    run_ticks(3, 32'h10000);
    chk("R6 rising blend w=128", sample_out, 16'h5000);
    run_ticks(1, 32'h40000);
    chk("R3 carry on exact wrap", req_seen, 3);
    run_ticks(1, 32'h13579);
    chk("R6 falling blend", sample_out, blend(32'h9000, 32'h0100, model_acc));
  endtask

  task automatic t_modulo;
    do_reset(1'b1);
    resp_list[0] = 16'hBEEF;
    run_ticks(1, 32'h7FFFF);
    chk("R3 max step without carry", req_seen, 0);
    run_ticks(1, 32'h7FFFF);
    chk("R3 modulo carry", req_seen, 1);
    interp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 top weight", sample_out, blend(32'h8000, 32'hBEEF, model_acc));
  endtask

  task automatic t_stray;
    do_reset(1'b1);
    resp_en = 1'b0;
    @(negedge clk);
    fetch_data = 16'h1234; fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 stray data leaves current", sample_out, 16'h8000);
    interp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 stray data leaves previous", sample_out, 16'h8000);
    resp_en = 1'b1;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_hold();
    t_rate();
    t_blend();
    t_modulo();
    t_stray();
    report();
  end
endmodule